// File: doc/BRIEF.md
# Dynamic Partial Shutdown Enable Controller

This block sits beside the digital sequencer of a current-mode buck converter and drives one enable line per analog helper block: soft-start ramp, error amplifier, oscillator, compensation ramp, ramp/sense adder, PWM comparator, current sense, over-current comparator, over-voltage comparator, reverse-current detector and output-voltage comparator. Within each switching cycle it looks at the live gate commands and the control mode. It powers down every helper that cannot influence the next switching decision, and it keeps running only those that can.

The block has two state machines. The switch machine has the states SOFT (soft-start running), HIGH (high-side gate on), LOW (low-side gate on) and IDLE (both gates off). Its transitions are as follows. SOFT leaves once soft-start completes. Any state goes back to SOFT when the soft-start-done flag drops. The named transition *cycle start* is any entry into HIGH. Among the other states, the next state follows the gates: HIGH when the high-side gate is on, else LOW when the low-side gate is on, else IDLE.

The wake machine has the states WK_IDLE, WK_COUNT and WK_ARMED. Its transitions are as follows. In PWM, a warning pulse seen in LOW or IDLE moves WK_IDLE to WK_COUNT. A further warning in WK_COUNT restarts the count. WK_COUNT moves to WK_ARMED after WAKE_AT = WARN_LEAD − WAKE_LEAD further clocks. A cycle start, a return to SOFT, or PFM mode sends the machine to WK_IDLE. While the machine is in WK_ARMED, the over-voltage comparator is woken ahead of the next high-side pulse. When the current-sense enable falls, a one-clock preset strobe tells that block to park its output at a known level.

Top module: `dps_enable_ctrl`

## Requirements
- R1: While ss_done is low, and during reset, all eleven enables are high and isns_preset is low. Every enable and the strobe are registered: they reflect the inputs sampled at the preceding rising clock edge.
- R2: While ss_done is high, en_soft is low in every mode and gate state.
- R3: When hs_gate and ls_gate are both high, the block behaves exactly as if only hs_gate were high.
- R4: In PWM (pfm_mode low) with hs_gate high, the following enables are high: en_erramp, en_osc, en_ramp, en_sum, en_pwmcmp, en_isns, en_ocp and en_ovp. en_rev and en_vcmp are low.
- R5: In PWM with only ls_gate high, en_erramp, en_osc and en_rev are high. en_ramp, en_sum, en_pwmcmp, en_isns, en_ocp and en_vcmp are low. en_ovp is low unless woken (R10).
- R6: In PWM with both gates off, only en_erramp and en_osc are high, apart from a woken en_ovp (R10).
- R7: In PFM (pfm_mode high) with hs_gate high, only en_isns, en_ocp and en_ovp are high.
- R8: In PFM with only ls_gate high, only en_rev and en_vcmp are high.
- R9: In PFM with both gates off, only en_vcmp is high.
- R10: In PWM, suppose a cyc_warn pulse is sampled in the LOW or IDLE state at edge k, and no cycle start follows. Then en_ovp rises at edge k+WAKE_AT and stays high through LOW and IDLE until the next cycle start.
- R11: cyc_warn has no effect when it is sampled in PFM, in SOFT or in HIGH. Any pending wake is also dropped when the block enters PFM or SOFT.
- R12: A cyc_warn sampled while a wake is still counting restarts the count. en_ovp then rises WAKE_AT edges after the last pulse.
- R13: isns_preset is high for exactly the one clock in which en_isns has just gone from high to low, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_done | input | 1 | Soft-start finished |
| pfm_mode | input | 1 | 1 = pulse-frequency mode, 0 = PWM |
| hs_gate | input | 1 | High-side switch command |
| ls_gate | input | 1 | Low-side switch command |
| cyc_warn | input | 1 | Early-warning pulse, WARN_LEAD clocks before the predicted cycle start |
| en_soft | output | 1 | Soft-start ramp enable |
| en_erramp | output | 1 | Error amplifier enable |
| en_osc | output | 1 | Oscillator enable |
| en_ramp | output | 1 | Compensation ramp generator enable |
| en_sum | output | 1 | Ramp/sense adder enable |
| en_pwmcmp | output | 1 | PWM comparator enable |
| en_isns | output | 1 | Current-sense enable |
| en_ocp | output | 1 | Over-current comparator enable |
| en_ovp | output | 1 | Over-voltage comparator enable |
| en_rev | output | 1 | Reverse-current detector enable |
| en_vcmp | output | 1 | Output-voltage comparator enable |
| isns_preset | output | 1 | One-clock preset strobe for the current sense |

## Verification
The bench builds the block with WARN_LEAD = 5 and WAKE_LEAD = 2, so WAKE_AT = 3. With these values a wake can arm, be restarted by a second warning and be cancelled by a cycle start within a few clocks. It can also be reached by random gate sequences that only sometimes pulse the high side. With such a short window, a count that is one clock early or late shows up as a mismatch on en_ovp at a predictable edge. The directed runs aim at this window, at both gates on together, at warnings that must be ignored, and at the preset strobe on each fall of the current-sense enable.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [1:0] {
        SW_SOFT = 2'd0,
        SW_HIGH = 2'd1,
        SW_LOW  = 2'd2,
        SW_IDLE = 2'd3
    } sw_state_t;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_COUNT = 2'd1,
        WK_ARMED = 2'd2
    } wk_state_t;

    localparam int NUM_EN    = 11;
    localparam int EN_SOFT   = 0;
    localparam int EN_ERRAMP = 1;
    localparam int EN_OSC    = 2;
    localparam int EN_RAMP   = 3;
    localparam int EN_SUM    = 4;
    localparam int EN_PWMCMP = 5;
    localparam int EN_ISNS   = 6;
    localparam int EN_OCP    = 7;
    localparam int EN_OVP    = 8;
    localparam int EN_REV    = 9;
    localparam int EN_VCMP   = 10;

    typedef logic [NUM_EN-1:0] en_vec_t;

endpackage

// File: rtl/dps_switch_fsm.sv
module dps_switch_fsm
    import dps_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ss_done,
    input  logic      hs_gate,
    input  logic      ls_gate,
    output sw_state_t sw_d,
    output logic      cyc_start
);

    sw_state_t sw_q;
    sw_state_t gate_pick;

    // high-side command wins if both gates are reported on
    always_comb begin
        if (hs_gate)
            gate_pick = SW_HIGH;
        else if (ls_gate)
            gate_pick = SW_LOW;
        else
            gate_pick = SW_IDLE;
    end

    always_comb begin
        unique case (sw_q)
            SW_SOFT: sw_d = ss_done ? gate_pick : SW_SOFT;
            SW_HIGH: sw_d = ss_done ? gate_pick : SW_SOFT;
            SW_LOW:  sw_d = ss_done ? gate_pick : SW_SOFT;
            SW_IDLE: sw_d = ss_done ? gate_pick : SW_SOFT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sw_q <= SW_SOFT;
        else
            sw_q <= sw_d;
    end

    assign cyc_start = (sw_d == SW_HIGH) && (sw_q != SW_HIGH);

endmodule

// File: rtl/dps_wake_timer.sv
module dps_wake_timer
    import dps_pkg::*;
#(
    parameter int WAKE_AT = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cyc_warn,
    input  logic      pfm_mode,
    input  sw_state_t sw_d,
    input  logic      cyc_start,
    output logic      wake_on
);

    localparam int CW = (WAKE_AT < 2) ? 1 : $clog2(WAKE_AT + 1);

    wk_state_t       wk_q, wk_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            drop_all;
    logic            warn_ok;

    assign drop_all = cyc_start || pfm_mode || (sw_d == SW_SOFT);
    assign warn_ok  = cyc_warn && (sw_d != SW_HIGH);

    always_comb begin
        wk_d  = wk_q;
        cnt_d = cnt_q;
        if (drop_all) begin
            wk_d  = WK_IDLE;
            cnt_d = '0;
        end else begin
            unique case (wk_q)
                WK_IDLE: begin
                    if (warn_ok) begin
                        wk_d  = WK_COUNT;
                        cnt_d = CW'(1);
                    end
                end
                WK_COUNT: begin
                    if (warn_ok) begin
                        cnt_d = CW'(1);
                    end else if (cnt_q == CW'(WAKE_AT)) begin
                        wk_d  = WK_ARMED;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                WK_ARMED: begin
                    wk_d = WK_ARMED;
                end
                default: begin
                    wk_d  = WK_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_q  <= WK_IDLE;
            cnt_q <= '0;
        end else begin
            wk_q  <= wk_d;
            cnt_q <= cnt_d;
        end
    end

    assign wake_on = (wk_d == WK_ARMED);

endmodule

// File: rtl/dps_en_decode.sv
module dps_en_decode
    import dps_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sw_state_t sw_d,
    input  logic      pfm_mode,
    input  logic      wake_on,
    output en_vec_t   en_q,
    output logic      preset_q
);

    en_vec_t en_d;

    always_comb begin
        en_d = '0;
        unique case (sw_d)
            SW_SOFT: begin
                en_d = '1;
            end
            SW_HIGH: begin
                en_d[EN_ERRAMP] = !pfm_mode;
                en_d[EN_OSC]    = !pfm_mode;
                en_d[EN_RAMP]   = !pfm_mode;
                en_d[EN_SUM]    = !pfm_mode;
                en_d[EN_PWMCMP] = !pfm_mode;
                en_d[EN_ISNS]   = 1'b1;
                en_d[EN_OCP]    = 1'b1;
                en_d[EN_OVP]    = 1'b1;
            end
            SW_LOW: begin
                en_d[EN_ERRAMP] = !pfm_mode;
                en_d[EN_OSC]    = !pfm_mode;
                en_d[EN_OVP]    = !pfm_mode && wake_on;
                en_d[EN_REV]    = 1'b1;
                en_d[EN_VCMP]   = pfm_mode;
            end
            SW_IDLE: begin
                en_d[EN_ERRAMP] = !pfm_mode;
                en_d[EN_OSC]    = !pfm_mode;
                en_d[EN_OVP]    = !pfm_mode && wake_on;
                en_d[EN_VCMP]   = pfm_mode;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '1;
            preset_q <= 1'b0;
        end else begin
            en_q     <= en_d;
            preset_q <= en_q[EN_ISNS] && !en_d[EN_ISNS];
        end
    end

endmodule

// File: rtl/dps_enable_ctrl.sv
module dps_enable_ctrl
    import dps_pkg::*;
#(
    parameter int WARN_LEAD = 8,
    parameter int WAKE_LEAD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_done,
    input  logic pfm_mode,
    input  logic hs_gate,
    input  logic ls_gate,
    input  logic cyc_warn,
    output logic en_soft,
    output logic en_erramp,
    output logic en_osc,
    output logic en_ramp,
    output logic en_sum,
    output logic en_pwmcmp,
    output logic en_isns,
    output logic en_ocp,
    output logic en_ovp,
    output logic en_rev,
    output logic en_vcmp,
    output logic isns_preset
);

    localparam int WAKE_AT = WARN_LEAD - WAKE_LEAD;

    sw_state_t sw_d;
    logic      cyc_start;
    logic      wake_on;
    en_vec_t   en_q;

    dps_switch_fsm u_sw (
        .clk       (clk),
        .rst_n     (rst_n),
        .ss_done   (ss_done),
        .hs_gate   (hs_gate),
        .ls_gate   (ls_gate),
        .sw_d      (sw_d),
        .cyc_start (cyc_start)
    );

    dps_wake_timer #(.WAKE_AT(WAKE_AT)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_warn  (cyc_warn),
        .pfm_mode  (pfm_mode),
        .sw_d      (sw_d),
        .cyc_start (cyc_start),
        .wake_on   (wake_on)
    );

    dps_en_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_d     (sw_d),
        .pfm_mode (pfm_mode),
        .wake_on  (wake_on),
        .en_q     (en_q),
        .preset_q (isns_preset)
    );

    assign en_soft   = en_q[EN_SOFT];
    assign en_erramp = en_q[EN_ERRAMP];
    assign en_osc    = en_q[EN_OSC];
    assign en_ramp   = en_q[EN_RAMP];
    assign en_sum    = en_q[EN_SUM];
    assign en_pwmcmp = en_q[EN_PWMCMP];
    assign en_isns   = en_q[EN_ISNS];
    assign en_ocp    = en_q[EN_OCP];
    assign en_ovp    = en_q[EN_OVP];
    assign en_rev    = en_q[EN_REV];
    assign en_vcmp   = en_q[EN_VCMP];

endmodule

// File: rtl/dps_enable_chk.sv
module dps_enable_chk (
    input logic clk,
    input logic rst_n,
    input logic ss_done,
    input logic pfm_mode,
    input logic hs_gate,
    input logic ls_gate,
    input logic en_soft,
    input logic en_erramp,
    input logic en_osc,
    input logic en_ramp,
    input logic en_sum,
    input logic en_pwmcmp,
    input logic en_isns,
    input logic en_ocp,
    input logic en_ovp,
    input logic en_rev,
    input logic en_vcmp,
    input logic isns_preset
);

    // R1
    soft_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_done |=> (en_soft && en_erramp && en_osc && en_ramp && en_sum && en_pwmcmp
                      && en_isns && en_ocp && en_ovp && en_rev && en_vcmp && !isns_preset));

    // R2
    soft_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |=> !en_soft);

    // R4
    pwm_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_done && !pfm_mode && hs_gate) |=> (!en_rev && en_isns && en_ocp && en_ovp));

    // R5
    pwm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_done && !pfm_mode && !hs_gate && ls_gate)
        |=> (!en_isns && !en_ocp && !en_ramp && !en_sum && !en_pwmcmp && en_rev));

    // R7
    pfm_loop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_done && pfm_mode) |=> !(en_erramp || en_osc || en_ramp || en_sum || en_pwmcmp));

    // R9
    pfm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_done && pfm_mode && !hs_gate && !ls_gate)
        |=> (en_vcmp && $countones({en_soft, en_erramp, en_osc, en_ramp, en_sum, en_pwmcmp,
                                    en_isns, en_ocp, en_ovp, en_rev}) == 0));

    // R11
    pfm_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_done && pfm_mode && !hs_gate) |=> !en_ovp);

    // R13
    preset_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isns_preset |-> (!en_isns && $past(en_isns)));

    // R13
    preset_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_isns) |-> isns_preset);

    // R13
    preset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isns_preset |=> !isns_preset);

endmodule

bind dps_enable_ctrl dps_enable_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ss_done     (ss_done),
    .pfm_mode    (pfm_mode),
    .hs_gate     (hs_gate),
    .ls_gate     (ls_gate),
    .en_soft     (en_soft),
    .en_erramp   (en_erramp),
    .en_osc      (en_osc),
    .en_ramp     (en_ramp),
    .en_sum      (en_sum),
    .en_pwmcmp   (en_pwmcmp),
    .en_isns     (en_isns),
    .en_ocp      (en_ocp),
    .en_ovp      (en_ovp),
    .en_rev      (en_rev),
    .en_vcmp     (en_vcmp),
    .isns_preset (isns_preset)
);

// File: tb/sim_dps_enable_ctrl.sv
`timescale 1ns/1ps
module sim_dps_enable_ctrl;

    localparam int WARN_LEAD = 5;
    localparam int WAKE_LEAD = 2;
    localparam int WAKE_AT   = WARN_LEAD - WAKE_LEAD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ss_done = 1'b0, pfm_mode = 1'b0, hs_gate = 1'b0, ls_gate = 1'b0, cyc_warn = 1'b0;
    logic en_soft, en_erramp, en_osc, en_ramp, en_sum, en_pwmcmp;
    logic en_isns, en_ocp, en_ovp, en_rev, en_vcmp, isns_preset;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // bench model state
    int m_prev_sw = 0;
    bit m_prev_isns = 1'b1;
    int m_age = -1;
    bit m_armed = 1'b0;

    always #5 clk = ~clk;

    dps_enable_ctrl #(.WARN_LEAD(WARN_LEAD), .WAKE_LEAD(WAKE_LEAD)) u0 (
        .clk(clk), .rst_n(rst_n), .ss_done(ss_done), .pfm_mode(pfm_mode),
        .hs_gate(hs_gate), .ls_gate(ls_gate), .cyc_warn(cyc_warn),
        .en_soft(en_soft), .en_erramp(en_erramp), .en_osc(en_osc), .en_ramp(en_ramp),
        .en_sum(en_sum), .en_pwmcmp(en_pwmcmp), .en_isns(en_isns), .en_ocp(en_ocp),
        .en_ovp(en_ovp), .en_rev(en_rev), .en_vcmp(en_vcmp), .isns_preset(isns_preset)
    );

    // bit order, MSB first: soft erramp osc ramp sum pwmcmp isns ocp ovp rev vcmp
    function automatic logic [10:0] exp_en(int sw, bit pfm, bit wake);
        case (sw)
            0:       return 11'b11111111111;
            1:       return pfm ? 11'b00000011100 : 11'b01111111100;
            2:       return pfm ? 11'b00000000011 : {8'b01100000, wake, 2'b10};
            default: return pfm ? 11'b00000000001 : {8'b01100000, wake, 2'b00};
        endcase
    endfunction

    function automatic string auto_tag(int sw, bit pfm, bit wake);
        if (sw == 0) return "R1";
        if (pfm) return (sw == 1) ? "R7" : (sw == 2) ? "R8" : "R9";
        if (sw == 1) return "R4";
        if (wake) return "R10";
        return (sw == 2) ? "R5" : "R6";
    endfunction

    function automatic logic [10:0] act_en();
        return {en_soft, en_erramp, en_osc, en_ramp, en_sum, en_pwmcmp,
                en_isns, en_ocp, en_ovp, en_rev, en_vcmp};
    endfunction

    task automatic compare(input logic [10:0] exp, input bit exp_pre, input string tg);
        checks++;
        if (act_en() !== exp || isns_preset !== exp_pre) begin
            failures++;
            $display("FAIL %s en=%b exp=%b preset=%b exp_preset=%b at %0t",
                     tg, act_en(), exp, isns_preset, exp_pre, $time);
        end
    endtask

    // Drive one sampled input set at a falling edge, check after the next rising edge.
    task automatic step(input bit ss, input bit pfm, input bit hs, input bit ls,
                        input bit warn, input string tg);
        int sw;
        bit start;
        logic [10:0] exp;
        bit exp_pre;
        string use_tag;
        ss_done = ss; pfm_mode = pfm; hs_gate = hs; ls_gate = ls; cyc_warn = warn;
        sw = !ss ? 0 : hs ? 1 : ls ? 2 : 3;
        start = (sw == 1) && (m_prev_sw != 1);
        if (start || sw == 0 || pfm) begin
            m_age = -1;
            m_armed = 1'b0;
        end else if (!m_armed) begin
            if (warn && sw != 1) m_age = 0;
            else if (m_age >= 0) m_age++;
            if (m_age >= WAKE_AT) m_armed = 1'b1;
        end
        exp = exp_en(sw, pfm, m_armed);
        exp_pre = m_prev_isns && !exp[4];
        m_prev_sw = sw;
        m_prev_isns = exp[4];
        use_tag = (tg == "") ? ((exp_pre || exp[4] != 1'b0 && 1'b0) ? "R13" : auto_tag(sw, pfm, m_armed)) : tg;
        if (tg == "" && exp_pre) use_tag = "R13";
        @(negedge clk);
        compare(exp, exp_pre, use_tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired checks=%0d", checks);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int r;
        bit pfm_r, ss_r, hs_r, ls_r, warn_r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        compare(11'b11111111111, 1'b0, "R1");
        rst_n = 1'b1;

        // R1: soft-start forces all enables high
        step(0, 0, 1, 0, 0, "R1");
        step(0, 1, 0, 1, 1, "R1");
        step(0, 1, 0, 0, 0, "R1");

        // R2: soft enable low in all six mode/gate states
        step(1, 0, 1, 0, 0, "R2");
        step(1, 0, 0, 1, 0, "R2");
        step(1, 0, 0, 0, 0, "R2");
        step(1, 1, 1, 0, 0, "R2");
        step(1, 1, 0, 1, 0, "R2");
        step(1, 1, 0, 0, 0, "R2");

        // R3: both gates on acts as high side
        step(1, 0, 1, 1, 0, "R3");
        step(1, 1, 1, 1, 0, "R3");
        step(1, 0, 1, 1, 0, "R3");

        // R13: high-side to low-side drops current sense -> strobe, then quiet
        step(1, 0, 1, 0, 0, "R13");
        step(1, 0, 0, 1, 0, "R13");
        step(1, 0, 0, 1, 0, "R13");

        // R10: warning in LOW, wake after WAKE_AT edges, held into IDLE, cleared by cycle start
        step(1, 0, 0, 1, 1, "R10");
        for (int i = 1; i <= WAKE_AT + 1; i++) step(1, 0, 0, 1, 0, "R10");
        step(1, 0, 0, 0, 0, "R10");
        step(1, 0, 1, 0, 0, "R10");
        step(1, 0, 0, 1, 0, "R10");
        step(1, 0, 0, 0, 0, "R10");

        // R12: second warning restarts the count
        step(1, 0, 0, 0, 1, "R12");
        step(1, 0, 0, 0, 0, "R12");
        step(1, 0, 0, 1, 1, "R12");
        for (int i = 1; i <= WAKE_AT + 1; i++) step(1, 0, 0, 1, 0, "R12");
        step(1, 0, 1, 0, 0, "R12");

        // R11: warnings in PFM, SOFT and HIGH are ignored
        step(1, 1, 0, 1, 1, "R11");
        for (int i = 0; i < WAKE_AT + 1; i++) step(1, 1, 0, 1, 0, "R11");
        for (int i = 0; i < WAKE_AT + 1; i++) step(1, 0, 0, 1, 0, "R11");
        step(0, 0, 0, 1, 1, "R11");
        for (int i = 0; i < WAKE_AT + 1; i++) step(1, 0, 0, 1, 0, "R11");
        step(1, 0, 1, 0, 1, "R11");
        for (int i = 0; i < WAKE_AT + 1; i++) step(1, 0, 0, 0, 0, "R11");
        // R11: pending wake dropped on entering PFM
        step(1, 0, 0, 1, 1, "R11");
        step(1, 1, 0, 1, 0, "R11");
        for (int i = 0; i < WAKE_AT + 1; i++) step(1, 0, 0, 1, 0, "R11");

        // random mix
        pfm_r = 1'b0;
        for (int n = 0; n < 3000; n++) begin
            if ($urandom % 16 == 0) pfm_r = !pfm_r;
            ss_r = ($urandom % 40) != 0;
            r = $urandom % 16;
            hs_r = (r < 4) || (r == 15);
            ls_r = (r >= 4 && r < 9) || (r == 15);
            warn_r = ($urandom % 6) == 0;
            step(ss_r, pfm_r, hs_r, ls_r, warn_r, "");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule